// File: doc/BRIEF.md
# Event-Sorting Hit Distributor

This block takes hit words from several parallel input links of one detector layer and sorts them into per-event output queues. Each hit word carries a pixel position and a bunch-crossing time stamp. Every link writes into its own small FIFO. A single router reads the FIFOs in rotating order and moves one word per cycle into the output queue picked by the word's time stamp. Each output queue feeds one downstream pattern matcher, one word per cycle, under that matcher's ready signal.

Events are closed in order. The oldest open event is finished once every link has shown that it has nothing more for it. A link shows this either by sending a hit with a later time stamp or by sending an end marker. When an event is finished, the router writes an end-of-event word into that event's output queue. A full output queue holds back only the FIFOs whose head word targets it, and no word is lost. A link whose own FIFO overflows raises a sticky flag.

The number of outputs must be a power of two, and the time stamp wraps at 256. Sources keep every link in time-stamp order and keep each link's hits within one output rotation of the oldest open event.

Top module: `hit_event_router`

## Requirements
- R1: A hit word holds the position in bits 31:8 and the time stamp in bits 7:0. Each hit leaves unchanged on output number (time stamp mod N_OUTS), and hits that share an output keep their order.
- R2: Each link FIFO holds LINK_DEPTH words. A word offered while its link FIFO is full is discarded, and that link's overflow flag is set and stays set until reset.
- R3: At most one link FIFO word is consumed per cycle. The router searches from the link after the last one served, in rising order with wrap, and skips links that are empty or blocked.
- R4: A hit whose target output queue is full stays at the head of its FIFO, and no data is lost. In the same cycle, other links whose heads can proceed are still served.
- R5: An input word with link_end=1 is an end marker. Bits 7:0 name the last event the link has finished. The marker is consumed by the router and never appears on an output.
- R6: The oldest open event E is 0 after reset. It closes once every link has either routed a hit with a later time stamp or routed an end marker at or after E, with time stamps compared modulo 256. On closing, the word {24'b0, E} with out_last=1 is written to output E mod N_OUTS, and E then advances by one.
- R7: Closing an event takes the cycle ahead of routing any word, and it waits while the target output queue is full.
- R8: Each output shows the head of its queue with out_valid. It advances by one word per cycle in which out_ready is high, and it holds the word stable while out_ready is low.
- R9: During reset, every out_valid and every link_ovf bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_valid | input | N_LINKS | Word present on each link |
| link_end | input | N_LINKS | Word is an end marker |
| link_data | input | N_LINKS*32 | Hit or marker word per link |
| link_ovf | output | N_LINKS | Sticky FIFO overflow flag per link |
| out_valid | output | N_OUTS | Output queue not empty |
| out_last | output | N_OUTS | Head word is an end-of-event word |
| out_data | output | N_OUTS*32 | Head word per output |
| out_ready | input | N_OUTS | Matcher accepts the head word |

## Verification
The bench builds the block with three links, four outputs, four-deep link FIFOs and two-deep output queues. Three links are not a power of two, so the round-robin wrap is checked at an uneven count. The two-deep queues fill within a few cycles, so blocked heads and stalled closes happen often under random ready patterns. Runs of several hundred events push the 8-bit time stamp through its wrap, where the modulo comparison of the closing rule matters.

// File: rtl/hit_router_pkg.sv
// Shared widths and time-stamp helpers for the event-sorting hit distributor.
// Assumes an 8-bit time stamp that wraps, with open events within half its range.
package hit_router_pkg;
    localparam int HIT_W  = 32;
    localparam int TS_W   = 8;
    localparam int POS_W  = HIT_W - TS_W;
    localparam int WORD_W = HIT_W + 1;

    typedef logic [TS_W-1:0] ts_t;

    // True when mark is at or after evt in wrapping time-stamp order.
    function automatic logic ts_reached(input ts_t mark, input ts_t evt);
        ts_t diff;
        diff = mark - evt;
        return ~diff[TS_W-1];
    endfunction
endpackage

// File: rtl/hr_sync_fifo.sv
// Synchronous FIFO with combinational head output.
// Assumes DEPTH is a power of two, and that the caller never writes when
// full nor reads when empty.
module hr_sync_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [AW:0]      count;

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Storage write, no reset needed on data.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    assign rd_data = mem[rd_ptr];
    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
endmodule

// File: rtl/hr_rr_arbiter.sv
// Rotating-priority picker: the first request at or after ptr, with wrap.
// Assumes ptr < N.
module hr_rr_arbiter #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    // Scan from farthest to nearest so the nearest request wins.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[(int'(ptr) + i) % N]) begin
                gnt_any = 1'b1;
                gnt_idx = IW'((int'(ptr) + i) % N);
            end
        end
    end
endmodule

// File: rtl/hr_event_tracker.sv
// Keeps the oldest open event and, per link, the last event that link has
// finished. Reports when every link has finished the oldest open event.
// Assumes each link's marks only move forward.
module hr_event_tracker
    import hit_router_pkg::*;
#(
    parameter int N_LINKS = 4,
    parameter int LW      = (N_LINKS > 1) ? $clog2(N_LINKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_en,
    input  logic [LW-1:0] upd_idx,
    input  ts_t           upd_mark,
    input  logic          adv,
    output ts_t           cur_evt,
    output logic          all_done
);
    ts_t              mark   [N_LINKS];
    logic [N_LINKS-1:0] mark_v;
    logic [N_LINKS-1:0] done;

    for (genvar l = 0; l < N_LINKS; l++) begin : g_link
        // Record the newest finished event of this link.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mark[l]   <= '0;
                mark_v[l] <= 1'b0;
            end else if (upd_en && upd_idx == LW'(l)) begin
                mark[l]   <= upd_mark;
                mark_v[l] <= 1'b1;
            end
        end
        assign done[l] = mark_v[l] && ts_reached(mark[l], cur_evt);
    end

    // Advance the oldest open event when it is closed.
    always_ff @(posedge clk) begin
        if (!rst_n)   cur_evt <= '0;
        else if (adv) cur_evt <= cur_evt + 1'b1;
    end

    assign all_done = &done;
endmodule

// File: rtl/hit_event_router.sv
// Event-sorting hit distributor: per-link FIFOs, a round-robin router that
// steers each hit by time stamp into output queue (ts mod N_OUTS), in-order
// event closing with end-of-event words, and per-output serial drain.
// Assumes N_OUTS, LINK_DEPTH and OUT_DEPTH are powers of two, links are in
// time-stamp order, and hits stay within N_OUTS events of the oldest open one.
module hit_event_router
    import hit_router_pkg::*;
#(
    parameter int N_LINKS    = 8,
    parameter int N_OUTS     = 8,
    parameter int LINK_DEPTH = 8,
    parameter int OUT_DEPTH  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINKS-1:0]        link_valid,
    input  logic [N_LINKS-1:0]        link_end,
    input  logic [N_LINKS*HIT_W-1:0]  link_data,
    output logic [N_LINKS-1:0]        link_ovf,
    output logic [N_OUTS-1:0]         out_valid,
    output logic [N_OUTS-1:0]         out_last,
    output logic [N_OUTS*HIT_W-1:0]   out_data,
    input  logic [N_OUTS-1:0]         out_ready
);
    localparam int LW = (N_LINKS > 1) ? $clog2(N_LINKS) : 1;
    localparam int OW = (N_OUTS > 1) ? $clog2(N_OUTS) : 1;

    logic [WORD_W-1:0]  lf_head  [N_LINKS];
    logic [N_LINKS-1:0] lf_empty;
    logic [N_LINKS-1:0] lf_full;
    logic [N_LINKS-1:0] lf_pop;
    logic [N_LINKS-1:0] req;
    logic [OW-1:0]      head_tgt [N_LINKS];

    logic [WORD_W-1:0]  oq_head  [N_OUTS];
    logic [N_OUTS-1:0]  oq_empty;
    logic [N_OUTS-1:0]  oq_full;
    logic [N_OUTS-1:0]  oq_wr;
    logic [WORD_W-1:0]  oq_wdata;

    logic [LW-1:0]      rr_ptr;
    logic               gnt_any;
    logic [LW-1:0]      gnt_idx;
    logic [WORD_W-1:0]  sel_word;
    logic               sel_end;
    ts_t                sel_ts;
    logic [OW-1:0]      sel_tgt;

    ts_t                cur_evt;
    logic               all_done;
    logic [OW-1:0]      close_tgt;
    logic               do_close;
    logic               do_route;
    ts_t                upd_mark;

    for (genvar l = 0; l < N_LINKS; l++) begin : g_in
        hr_sync_fifo #(.WIDTH(WORD_W), .DEPTH(LINK_DEPTH)) u_link_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (link_valid[l] && !lf_full[l]),
            .wr_data ({link_end[l], link_data[l*HIT_W +: HIT_W]}),
            .rd_en   (lf_pop[l]),
            .rd_data (lf_head[l]),
            .empty   (lf_empty[l]),
            .full    (lf_full[l])
        );

        // Sticky flag for a word lost to a full link FIFO.
        always_ff @(posedge clk) begin
            if (!rst_n)                          link_ovf[l] <= 1'b0;
            else if (link_valid[l] && lf_full[l]) link_ovf[l] <= 1'b1;
        end

        assign head_tgt[l] = OW'(lf_head[l][TS_W-1:0] % N_OUTS);
        assign req[l]      = !lf_empty[l] &&
                             (lf_head[l][HIT_W] || !oq_full[head_tgt[l]]);
        assign lf_pop[l]   = do_route && (gnt_idx == LW'(l));
    end

    hr_rr_arbiter #(.N(N_LINKS), .IW(LW)) u_arb (
        .req     (req),
        .ptr     (rr_ptr),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    assign sel_word  = lf_head[gnt_idx];
    assign sel_end   = sel_word[HIT_W];
    assign sel_ts    = sel_word[TS_W-1:0];
    assign sel_tgt   = OW'(sel_ts % N_OUTS);
    assign close_tgt = OW'(cur_evt % N_OUTS);
    assign do_close  = all_done && !oq_full[close_tgt];
    assign do_route  = !do_close && gnt_any;
    assign upd_mark  = sel_end ? sel_ts : sel_ts - ts_t'(1);

    // Word written into an output queue this cycle.
    always_comb begin
        if (do_close) oq_wdata = {1'b1, {POS_W{1'b0}}, cur_evt};
        else          oq_wdata = {1'b0, sel_word[HIT_W-1:0]};
    end

    // Rotate the search start past the link just served.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rr_ptr <= '0;
        else if (do_route)
            rr_ptr <= (gnt_idx == LW'(N_LINKS - 1)) ? '0 : gnt_idx + 1'b1;
    end

    hr_event_tracker #(.N_LINKS(N_LINKS), .LW(LW)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_en   (do_route),
        .upd_idx  (gnt_idx),
        .upd_mark (upd_mark),
        .adv      (do_close),
        .cur_evt  (cur_evt),
        .all_done (all_done)
    );

    for (genvar o = 0; o < N_OUTS; o++) begin : g_out
        assign oq_wr[o] = (do_close && close_tgt == OW'(o)) ||
                          (do_route && !sel_end && sel_tgt == OW'(o));

        hr_sync_fifo #(.WIDTH(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (oq_wr[o]),
            .wr_data (oq_wdata),
            .rd_en   (out_ready[o] && !oq_empty[o]),
            .rd_data (oq_head[o]),
            .empty   (oq_empty[o]),
            .full    (oq_full[o])
        );

        assign out_valid[o]                = !oq_empty[o];
        assign out_last[o]                 = oq_head[o][HIT_W];
        assign out_data[o*HIT_W +: HIT_W]  = oq_head[o][HIT_W-1:0];
    end
endmodule

// File: rtl/hit_event_router_checker.sv
// Port-level properties of the hit distributor, attached by bind below.
module hit_event_router_checker #(
    parameter int N_LINKS = 8,
    parameter int N_OUTS  = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [N_LINKS-1:0]     link_ovf,
    input logic [N_OUTS-1:0]      out_valid,
    input logic [N_OUTS-1:0]      out_last,
    input logic [N_OUTS*32-1:0]   out_data,
    input logic [N_OUTS-1:0]      out_ready
);
    for (genvar l = 0; l < N_LINKS; l++) begin : g_l
        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            link_ovf[l] |=> link_ovf[l]); // R2
    end

    for (genvar o = 0; o < N_OUTS; o++) begin : g_o
        AST_HIT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_last[o] |-> (out_data[o*32 +: 8] % N_OUTS) == o); // R1
        AST_EOE_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && out_last[o] |->
                out_data[o*32+8 +: 24] == 24'd0 && (out_data[o*32 +: 8] % N_OUTS) == o); // R6
        AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[o] && !out_ready[o] |=>
                out_valid[o] && $stable(out_data[o*32 +: 32]) && $stable(out_last[o])); // R8
    end
endmodule

bind hit_event_router hit_event_router_checker #(
    .N_LINKS(N_LINKS),
    .N_OUTS (N_OUTS)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_ovf  (link_ovf),
    .out_valid (out_valid),
    .out_last  (out_last),
    .out_data  (out_data),
    .out_ready (out_ready)
);

// File: tb/hit_event_router_bench.sv
`timescale 1ns/1ps
module hit_event_router_bench;
    localparam int L  = 3;
    localparam int O  = 4;
    localparam int LD = 4;
    localparam int QD = 2;

    logic               clk;
    logic               rst_n;
    logic [L-1:0]       link_valid;
    logic [L-1:0]       link_end;
    logic [L*32-1:0]    link_data;
    logic [L-1:0]       link_ovf;
    logic [O-1:0]       out_valid;
    logic [O-1:0]       out_last;
    logic [O*32-1:0]    out_data;
    logic [O-1:0]       out_ready;

    hit_event_router #(.N_LINKS(L), .N_OUTS(O), .LINK_DEPTH(LD), .OUT_DEPTH(QD))
    u_hit_event_router (
        .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_end(link_end),
        .link_data(link_data), .link_ovf(link_ovf), .out_valid(out_valid),
        .out_last(out_last), .out_data(out_data), .out_ready(out_ready)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    // Reference model state
    typedef struct { bit e; int ev; logic [23:0] pos; } ent_t;
    ent_t        fq [L][$];
    logic [32:0] oq [O][$];
    int          wm [L];
    bit          m_ovf [L];
    int          m_cur, m_rr;
    int          drv_ev [L];
    bit          full_old [L];
    int          sz_old [O];
    bit          have_w, all_done, won;
    int          pend_o, k;
    logic [32:0] pend_w;
    ent_t        h, nw;

    int  nchk, nfail, dut_marks;
    int  gen_e [L];
    int  gen_stop;
    string ph;

    // Behavioural reference, one update per clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int l = 0; l < L; l++) begin fq[l].delete(); wm[l] = -1; m_ovf[l] = 0; end
            for (int o = 0; o < O; o++) oq[o].delete();
            m_cur = 0; m_rr = 0;
        end else begin
            for (int l = 0; l < L; l++) full_old[l] = (fq[l].size() == LD);
            for (int o = 0; o < O; o++) sz_old[o] = oq[o].size();
            all_done = 1;
            for (int l = 0; l < L; l++) if (wm[l] < m_cur) all_done = 0;
            have_w = 0;
            if (all_done && sz_old[m_cur % O] < QD) begin
                have_w = 1; pend_o = m_cur % O;
                pend_w = {1'b1, 24'd0, 8'(m_cur)};
                m_cur++;
            end else begin
                won = 0;
                for (int i = 0; i < L; i++) begin
                    k = (m_rr + i) % L;
                    if (!won && fq[k].size() > 0) begin
                        h = fq[k][0];
                        if (h.e || sz_old[h.ev % O] < QD) begin
                            won = 1;
                            void'(fq[k].pop_front());
                            if (h.e) wm[k] = h.ev;
                            else begin
                                have_w = 1; pend_o = h.ev % O;
                                pend_w = {1'b0, h.pos, 8'(h.ev)};
                                wm[k] = h.ev - 1;
                            end
                            m_rr = (k + 1) % L;
                        end
                    end
                end
            end
            for (int o = 0; o < O; o++)
                if (oq[o].size() > 0 && out_ready[o]) void'(oq[o].pop_front());
            if (have_w) oq[pend_o].push_back(pend_w);
            for (int l = 0; l < L; l++) if (link_valid[l]) begin
                if (full_old[l]) m_ovf[l] = 1;
                else begin
                    nw.e = link_end[l]; nw.ev = drv_ev[l];
                    nw.pos = link_data[l*32+8 +: 24];
                    fq[l].push_back(nw);
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint got, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s (%s) %s: got %0h expected %0h", tag, ph, what, got, exp);
        end
    endtask

    // Compare all outputs against the model (sampled at the falling edge).
    task automatic compare_all();
        for (int o = 0; o < O; o++) begin
            chk(out_valid[o] == (oq[o].size() > 0), "R8", $sformatf("out_valid[%0d]", o),
                out_valid[o], oq[o].size() > 0);
            if (oq[o].size() > 0 && out_valid[o]) begin
                chk(out_data[o*32 +: 32] == oq[o][0][31:0], "R1", $sformatf("out_data[%0d]", o),
                    out_data[o*32 +: 32], oq[o][0][31:0]);
                chk(out_last[o] == oq[o][0][32], "R6", $sformatf("out_last[%0d]", o),
                    out_last[o], oq[o][0][32]);
            end
        end
        for (int l = 0; l < L; l++)
            chk(link_ovf[l] == m_ovf[l], "R2", $sformatf("link_ovf[%0d]", l), link_ovf[l], m_ovf[l]);
    endtask

    // One cycle: check, then drive the next inputs.
    task automatic cycle(input int ready_pct, input bit ovf_mode, input bit drain);
        @(negedge clk);
        compare_all();
        link_valid = '0; link_end = '0;
        for (int o = 0; o < O; o++) out_ready[o] = (($urandom % 100) < ready_pct);
        for (int l = 0; l < L; l++) begin
            if (ovf_mode) begin
                if (l == 0) begin
                    link_valid[0] = 1; drv_ev[0] = gen_e[0];
                    link_data[0 +: 32] = {24'($urandom), 8'(gen_e[0])};
                end
            end else if (gen_e[l] < gen_stop && gen_e[l] < m_cur + O &&
                         fq[l].size() < LD && ($urandom % 100) < 60) begin
                link_valid[l] = 1;
                link_end[l] = drain || (($urandom % 3) == 0);
                drv_ev[l] = gen_e[l];
                link_data[l*32 +: 32] = {24'($urandom), 8'(gen_e[l])};
                if (link_end[l]) gen_e[l]++;
            end
        end
        for (int o = 0; o < O; o++)
            if (out_valid[o] && out_ready[o] && out_last[o]) dut_marks++;
    endtask

    initial begin
        int target;
        nchk = 0; nfail = 0; dut_marks = 0; gen_stop = 1 << 30;
        for (int l = 0; l < L; l++) begin gen_e[l] = 0; drv_ev[l] = 0; end
        link_valid = '0; link_end = '0; link_data = '0; out_ready = '0;
        rst_n = 0; ph = "reset";
        repeat (3) @(posedge clk);
        @(negedge clk);
        for (int o = 0; o < O; o++) chk(out_valid[o] == 0, "R9", "out_valid in reset", out_valid[o], 0);
        chk(link_ovf == '0, "R9", "link_ovf in reset", link_ovf, 0);
        rst_n = 1;

        ph = "R3 fair mix";            repeat (400)  cycle(100, 0, 0);
        ph = "R4 backpressure";        repeat (800)  cycle(40, 0, 0);
        ph = "R4 stalled outputs";     repeat (60)   cycle(0, 0, 0);
        ph = "R5 R7 long run and wrap"; repeat (3000) cycle(90, 0, 0);
        ph = "R2 overflow";            repeat (20)   cycle(0, 1, 0);
        @(negedge clk);
        chk(link_ovf[0] == 1, "R2", "overflow flag link 0", link_ovf[0], 1);
        chk(link_ovf[L-1:1] == '0, "R2", "overflow flag other links", link_ovf[L-1:1], 0);
        chk(m_cur > 256, "R6", "events closed across wrap", m_cur, 257);

        ph = "R6 drain";
        target = 0;
        for (int l = 0; l < L; l++) if (gen_e[l] > target) target = gen_e[l];
        target += 2; gen_stop = target;
        for (int i = 0; i < 3000; i++) begin
            int busy;
            busy = (m_cur < target) ? 1 : 0;
            for (int o = 0; o < O; o++) if (oq[o].size() > 0) busy = 1;
            if (busy == 0) break;
            cycle(100, 0, 1);
        end
        repeat (3) cycle(100, 0, 0);
        chk(out_valid == '0, "R6", "outputs idle after drain", out_valid, 0);
        chk(dut_marks == target, "R6", "end-of-event words delivered", dut_marks, target);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R6 watchdog: got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule